// File: doc/BRIEF.md
# Peripheral Card Control and Flag Logic

This block holds the three state bits that every peripheral interface card keeps: a control bit that enables the card, a flag bit that marks work as done, and a flag buffer that stages completion ahead of the flag. The card's address decoder drives it with single-cycle strobes: set or clear control, set or clear flag, the two skip tests, enable-flag, control reset, power-on preset, interrupt acknowledge and the request update strobe. The card's own datapath raises a one-cycle device-done pulse when a transfer finishes.

The block answers a skip test at once, using the flag value held before any clear-flag in the same cycle. Three request outputs are produced: interrupt request, service request for the DMA engine, and priority-low out. They are not recomputed on every state change. They are recomputed from the new state only in a cycle that carries the request update strobe. Priority-low runs through a daisy chain of cards. A card that is enabled and flagged breaks the chain for every card below it, and it can raise its interrupt only while priority from above is present.

Top module: `card_ctl_flag`

## Requirements
- R1: After reset, control, flag and flag buffer are 0, `irq_out` and `srq_out` are 0, and `prl_out` equals `pri_in`.
- R2: `stb_stc` sets control and `stb_clc` clears it; when both arrive in one cycle, the clear wins. `stb_crs` also clears control and overrides `stb_stc`.
- R3: `stb_stf` sets both flag and flag buffer. `dev_done` sets the flag buffer only and leaves the flag unchanged.
- R4: `stb_enf` sets the flag only if the flag buffer was already set before the cycle; otherwise the flag is unchanged.
- R5: `stb_clf` clears both flag and flag buffer, and it wins over `stb_stf`, `stb_enf` and `dev_done` in the same cycle.
- R6: `skip_out` = (`stb_sfs` AND flag) OR (`stb_sfc` AND NOT flag), evaluated combinationally from the flag held before the current cycle's strobes take effect. A concurrent `stb_clf` therefore does not alter that cycle's answer.
- R7: `stb_popio` sets both flag and flag buffer, and it wins over `stb_clf`.
- R8: `stb_iak` clears the flag buffer and wins over every other strobe. It leaves the flag and control unchanged.
- R9: The request terms are taken only in a cycle with `stb_sir`, from the state the cycle's strobes produce, and they appear one cycle later. The terms are: interrupt term = control AND flag AND buffer, service term = flag, low-priority term = NOT (control AND flag). Without `stb_sir` they hold their values.
- R10: `irq_out` = interrupt term AND `pri_in`; `prl_out` = low-priority term AND `pri_in`; `srq_out` = service term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_stc | input | 1 | Set-control strobe |
| stb_clc | input | 1 | Clear-control strobe |
| stb_stf | input | 1 | Set-flag strobe |
| stb_clf | input | 1 | Clear-flag strobe |
| stb_sfs | input | 1 | Skip-if-flag-set test |
| stb_sfc | input | 1 | Skip-if-flag-clear test |
| stb_enf | input | 1 | Enable-flag strobe |
| stb_crs | input | 1 | Control reset strobe |
| stb_popio | input | 1 | Power-on preset strobe |
| stb_iak | input | 1 | Interrupt acknowledge for this card |
| stb_sir | input | 1 | Request update strobe |
| dev_done | input | 1 | Device completion pulse |
| pri_in | input | 1 | Priority from the card above |
| irq_out | output | 1 | Interrupt request |
| srq_out | output | 1 | Service request to DMA |
| prl_out | output | 1 | Priority to the card below |
| skip_out | output | 1 | Skip-on-flag response |

## Verification
The assertions assume every strobe is sampled once at a clock edge. They place no limit on which strobes arrive together, so the conflict rules in R2, R5, R7 and R8 are asserted under arbitrary overlap. The stimulus first drives directed cycles that isolate each rule. It then drives a long run of cycles in which every strobe and `pri_in` is drawn independently, which produces the concurrent combinations. A behavioural model in the bench, which applies the strobes one after another in a fixed order, predicts every output in every cycle.

// File: rtl/card_flags_pkg.sv
package card_flags_pkg;

  typedef struct packed {
    logic stc;
    logic clc;
    logic stf;
    logic clf;
    logic enf;
    logic crs;
    logic popio;
    logic iak;
    logic done;
  } strobe_t;

  typedef struct packed {
    logic ctrl;
    logic flag;
    logic fbuf;
  } ff_t;

  localparam ff_t FF_RESET = '{ctrl: 1'b0, flag: 1'b0, fbuf: 1'b0};

  // Strobes act in a fixed order; a later step overrides an earlier one.
  function automatic ff_t ff_next(ff_t s, strobe_t t);
    ff_t n;
    n = s;
    if (t.enf && s.fbuf) n.flag = 1'b1;
    if (t.done) n.fbuf = 1'b1;
    if (t.stc) n.ctrl = 1'b1;
    if (t.clc) n.ctrl = 1'b0;
    if (t.stf) begin n.flag = 1'b1; n.fbuf = 1'b1; end
    if (t.clf) begin n.flag = 1'b0; n.fbuf = 1'b0; end
    if (t.crs) n.ctrl = 1'b0;
    if (t.popio) begin n.flag = 1'b1; n.fbuf = 1'b1; end
    if (t.iak) n.fbuf = 1'b0;
    return n;
  endfunction

  function automatic logic irq_term(ff_t s);
    return s.ctrl & s.flag & s.fbuf;
  endfunction

  function automatic logic srq_term(ff_t s);
    return s.flag;
  endfunction

  function automatic logic prl_term(ff_t s);
    return ~(s.ctrl & s.flag);
  endfunction

  function automatic logic skip_term(logic flag, logic sfs, logic sfc);
    return (sfs & flag) | (sfc & ~flag);
  endfunction

endpackage

// File: rtl/card_flop_core.sv
module card_flop_core
  import card_flags_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  output ff_t     state_q,
  output ff_t     state_n
);

  assign state_n = ff_next(state_q, stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FF_RESET;
    else        state_q <= state_n;
  end

  // Events brought out for the assertions
  logic ev_ctrl_kill, ev_enf_blocked, ev_iak, ev_preset_win;
  assign ev_ctrl_kill   = stb.clc | stb.crs;
  assign ev_enf_blocked = stb.enf & ~state_q.fbuf & ~stb.stf & ~stb.popio & ~stb.clf;
  assign ev_iak         = stb.iak;
  assign ev_preset_win  = stb.popio & ~stb.iak;

  a_r2_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_kill |=> !state_q.ctrl);
  a_r4_enf_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enf_blocked |=> state_q.flag == $past(state_q.flag));
  a_r8_iak_clears_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iak |=> !state_q.fbuf);
  a_r7_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_preset_win |=> state_q.flag && state_q.fbuf);
  a_r5_clf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clf && !stb.popio) |=> !state_q.flag);

endmodule

// File: rtl/card_req_logic.sv
module card_req_logic
  import card_flags_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sir,
  input  ff_t  state_q,
  input  ff_t  state_n,
  input  logic pri_in,
  input  logic sfs,
  input  logic sfc,
  output logic irq_out,
  output logic srq_out,
  output logic prl_out,
  output logic skip_out
);

  logic irq_q, srq_q, prl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      srq_q <= 1'b0;
      prl_q <= 1'b1;
    end else if (sir) begin
      irq_q <= irq_term(state_n);
      srq_q <= srq_term(state_n);
      prl_q <= prl_term(state_n);
    end
  end

  assign irq_out  = irq_q & pri_in;
  assign srq_out  = srq_q;
  assign prl_out  = prl_q & pri_in;
  assign skip_out = skip_term(state_q.flag, sfs, sfc);

  a_r9_sir_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    sir |=> (irq_q == (state_q.ctrl & state_q.flag & state_q.fbuf)) &&
            (srq_q == state_q.flag));
  a_r9_hold_without_sir: assert property (@(posedge clk) disable iff (!rst_n)
    !sir |=> $stable(irq_q) && $stable(srq_q) && $stable(prl_q));
  a_r10_irq_prl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_out && prl_out));
  a_r6_skip_sfs: assert property (@(posedge clk) disable iff (!rst_n)
    (sfs && !sfc && state_q.flag) |-> skip_out);

endmodule

// File: rtl/card_ctl_flag.sv
module card_ctl_flag
  import card_flags_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_stc,
  input  logic stb_clc,
  input  logic stb_stf,
  input  logic stb_clf,
  input  logic stb_sfs,
  input  logic stb_sfc,
  input  logic stb_enf,
  input  logic stb_crs,
  input  logic stb_popio,
  input  logic stb_iak,
  input  logic stb_sir,
  input  logic dev_done,
  input  logic pri_in,
  output logic irq_out,
  output logic srq_out,
  output logic prl_out,
  output logic skip_out
);

  strobe_t stb;
  ff_t     state_q, state_n;

  assign stb = '{stc: stb_stc, clc: stb_clc, stf: stb_stf, clf: stb_clf,
                 enf: stb_enf, crs: stb_crs, popio: stb_popio,
                 iak: stb_iak, done: dev_done};

  card_flop_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .state_q (state_q),
    .state_n (state_n)
  );

  card_req_logic u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .sir      (stb_sir),
    .state_q  (state_q),
    .state_n  (state_n),
    .pri_in   (pri_in),
    .sfs      (stb_sfs),
    .sfc      (stb_sfc),
    .irq_out  (irq_out),
    .srq_out  (srq_out),
    .prl_out  (prl_out),
    .skip_out (skip_out)
  );

  a_r10_no_priority_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_in |-> !irq_out && !prl_out);

endmodule

// File: tb/card_ctl_flag_tb_top.sv
module card_ctl_flag_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stc = 0, clc = 0, stf = 0, clf = 0, sfs = 0, sfc = 0, enf = 0;
  logic crs = 0, popio = 0, iak = 0, sir = 0, done = 0, pri = 1;
  logic irq, srq, prl, skip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference state
  bit m_ctrl, m_flag, m_buf, m_irq, m_srq, m_prl;

  always #10 clk = ~clk;

  card_ctl_flag dut_i (
    .clk(clk), .rst_n(rst_n),
    .stb_stc(stc), .stb_clc(clc), .stb_stf(stf), .stb_clf(clf),
    .stb_sfs(sfs), .stb_sfc(sfc), .stb_enf(enf), .stb_crs(crs),
    .stb_popio(popio), .stb_iak(iak), .stb_sir(sir), .dev_done(done),
    .pri_in(pri),
    .irq_out(irq), .srq_out(srq), .prl_out(prl), .skip_out(skip)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    {stc, clc, stf, clf, sfs, sfc, enf, crs, popio, iak, sir, done} = '0;
  endtask

  // Model step: strobes processed one at a time
  task automatic model_step();
    bit c, f, b;
    c = m_ctrl; f = m_flag; b = m_buf;
    if (enf && m_buf) f = 1;
    if (done) b = 1;
    if (stc) c = 1;
    if (clc) c = 0;
    if (stf) begin f = 1; b = 1; end
    if (clf) begin f = 0; b = 0; end
    if (crs) c = 0;
    if (popio) begin f = 1; b = 1; end
    if (iak) b = 0;
    if (sir) begin
      m_irq = c && f && b;
      m_srq = f;
      m_prl = !(c && f);
    end
    m_ctrl = c; m_flag = f; m_buf = b;
  endtask

  // One cycle: check registered outputs, apply strobes, check skip, clock.
  task automatic cyc(input string req);
    @(negedge clk);
    chk(req, "irq_out", irq, m_irq && pri);
    chk(req, "srq_out", srq, m_srq);
    chk(req, "prl_out", prl, m_prl && pri);
    #2;
    chk("R6", "skip_out", skip, (sfs && m_flag) || (sfc && !m_flag));
    @(posedge clk);
    model_step();
    #1 clear_in();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_prl = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq_out", irq, 0);
    chk("R1", "srq_out", srq, 0);
    chk("R1", "prl_out", prl, 1);
    pri = 0; #1 chk("R1", "prl_out follows pri_in", prl, 0); pri = 1;
    rst_n = 1;

    // R2 set control then clear wins
    stc = 1; sir = 1; cyc("R2");
    stc = 1; clc = 1; sir = 1; cyc("R2");
    stc = 1; sir = 1; cyc("R2");
    // R3 set flag -> irq
    stf = 1; sir = 1; cyc("R3");
    cyc("R9");
    // R6 skip with concurrent clear
    sfs = 1; clf = 1; cyc("R6");
    sfc = 1; cyc("R6");
    // R9 no update without SIR
    stf = 1; cyc("R9");
    cyc("R9");
    sir = 1; cyc("R9");
    cyc("R9");
    // R4 enf with empty buffer
    clf = 1; sir = 1; cyc("R5");
    enf = 1; sir = 1; cyc("R4");
    // R3 done then enf
    done = 1; sir = 1; cyc("R3");
    sfs = 1; cyc("R3");
    enf = 1; sir = 1; cyc("R4");
    sfs = 1; cyc("R4");
    // R8 iak
    iak = 1; sir = 1; cyc("R8");
    stf = 1; iak = 1; popio = 1; sir = 1; cyc("R8");
    // R7 preset and crs
    clf = 1; popio = 1; crs = 1; sir = 1; cyc("R7");
    cyc("R7");
    // R5 clf beats stf and done
    stc = 1; stf = 1; clf = 1; done = 1; sir = 1; cyc("R5");
    // R10 priority chain
    stf = 1; sir = 1; cyc("R10");
    pri = 0; cyc("R10");
    pri = 1; cyc("R10");

    // Random overlap
    for (int i = 0; i < 3000; i++) begin
      stc = ($urandom % 4) == 0; clc = ($urandom % 5) == 0;
      stf = ($urandom % 5) == 0; clf = ($urandom % 5) == 0;
      sfs = ($urandom % 3) == 0; sfc = ($urandom % 3) == 0;
      enf = ($urandom % 3) == 0; crs = ($urandom % 12) == 0;
      popio = ($urandom % 15) == 0; iak = ($urandom % 8) == 0;
      sir = ($urandom % 2) == 0; done = ($urandom % 4) == 0;
      pri = ($urandom % 6) != 0;
      cyc("R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule